// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Request Scheduler

This block issues the housekeeping commands a synchronous DRAM needs, separate from processor traffic. It does not drive memory pins. Instead, it sends command requests over a single request/acknowledge channel to the central command sequencer. The sequencer carries out each command and acknowledges it.

The block leaves reset idle. It waits for an enable line that may change at any time relative to the clock, and brings that line into the clock domain through two flip-flops. When the enable is seen high, it waits a programmable power-up delay. It then requests a precharge of all banks, two auto-refresh cycles and a mode-register load, and then reports that initialization is complete. The mode word sent with the load is built at elaboration time from parameters for CAS latency, burst length, burst ordering and write burst behaviour.

Once initialization is complete, a free-running interval counter raises a refresh request once per period. The default period is 1560 cycles, which is 15.6 µs at 100 MHz.

Top module: `dramUpkeepSched`

## Requirements
- R1: While reset is active, and while the synchronized enable stays low after reset, `reqValid` and `initDone` stay low.
- R2: If `enableAsync` rises between two clock edges, the first request is raised on the (POWERUP_CYCLES+3)-th rising edge after that point. That count is two synchronizer stages, one state step and the power-up delay.
- R3: The initialization requests come in this order: precharge-all (`reqKind`=0), auto-refresh (`reqKind`=1), auto-refresh (1), then mode-register load (`reqKind`=2).
- R4: A request and its kind stay unchanged until an edge at which `reqAck` is high. On that edge the channel advances, either to the next initialization request or to idle.
- R5: `initDone` rises on the edge that accepts the mode-register load, and it stays high until reset.
- R6: `modeWord` holds the following fields, with every other bit zero:
  - bits 2:0: burst length (000=1, 001=2, 010=4, 011=8, 111=full page)
  - bit 3: burst ordering (1 = interleaved)
  - bits 6:4: CAS latency
  - bit 9: single-location write bursts
- R7: The first refresh request (`reqKind`=1) rises REFRESH_PERIOD cycles after `initDone` rises. Later expiries follow every REFRESH_PERIOD cycles in the same phase, whenever the acknowledges arrive.
- R8: Period expiries that occur while a refresh request is still pending merge into that one request. A single acknowledge clears it, and the channel is idle on the next cycle.
- R9: An acknowledge that falls in the same cycle as a period expiry retires the old request, and the new request stays raised with no idle cycle in between.
- R10: `reqAck` has no effect while `reqValid` is low. It neither starts a request nor shifts the refresh phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enableAsync | input | 1 | Start enable, asynchronous to `clk` |
| reqAck | input | 1 | Sequencer accepts the current request |
| reqValid | output | 1 | A command request is pending |
| reqKind | output | 2 | 0 precharge-all, 1 auto-refresh, 2 mode-register load |
| modeWord | output | 12 | Mode register value for the load command |
| initDone | output | 1 | Power-up sequence complete |

## Verification
Two functions can fall in the same cycle: an acknowledge retiring the current refresh request, and the interval counter expiring.

The bench provokes this by holding a refresh request for exactly one period and then asserting the acknowledge in the cycle just before the next expiry edge. It judges the result correct when `reqValid` stays high across that edge and a second acknowledge is still needed to clear it. The case where acknowledges come late, with two expiries merged, is also driven. In both cases the following rise must land on the original period phase.

// File: rtl/memInitPkg.sv
package memInitPkg;

  localparam int MODE_W = 12;

  typedef enum logic [1:0] {
    KIND_PRECHARGE = 2'd0,
    KIND_REFRESH   = 2'd1,
    KIND_MODELOAD  = 2'd2
  } reqKind_e;

  typedef enum logic [2:0] {
    ST_WAITEN,
    ST_PWRUP,
    ST_PRE,
    ST_REF1,
    ST_REF2,
    ST_MRS,
    ST_RUN
  } upkeepState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic puRun;
    logic refRun;
  } ctrlStrobe_t;

  function automatic logic [MODE_W-1:0] buildModeWord(int casLat, int burstLen,
                                                      bit interleave, bit singleWrite);
    logic [MODE_W-1:0] w;
    w = '0;
    case (burstLen)
      1:       w[2:0] = 3'b000;
      2:       w[2:0] = 3'b001;
      4:       w[2:0] = 3'b010;
      8:       w[2:0] = 3'b011;
      default: w[2:0] = 3'b111;  // full page
    endcase
    w[3]   = interleave;
    w[6:4] = 3'(casLat);
    w[9]   = singleWrite;
    return w;
  endfunction

endpackage

// File: rtl/memInitDatapath.sv
module memInitDatapath
  import memInitPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PU_CYCLES   = 10000,
  parameter int REF_PERIOD  = 1560,
  parameter int REF_W       = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enableAsync,
  input  ctrlStrobe_t strobe,
  output logic        enSync,
  output logic        puDone,
  output logic        refTick
);

  localparam int PU_W = $clog2(PU_CYCLES + 1);

  // Enable synchronizer chain
  logic [SYNC_STAGES-1:0] syncQ;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else if (s == 0) syncQ[s] <= enableAsync;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign enSync = syncQ[SYNC_STAGES-1];

  // Power-up delay counter
  logic [PU_W-1:0] puCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              puCnt <= '0;
    else if (!strobe.puRun) puCnt <= '0;
    else                    puCnt <= puCnt + 1'b1;
  end

  assign puDone = strobe.puRun && (puCnt == PU_W'(PU_CYCLES - 1));

  // Refresh interval counter, reloads on every expiry
  logic [REF_W-1:0] refCnt;

  assign refTick = strobe.refRun && (refCnt == REF_W'(REF_PERIOD - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               refCnt <= '0;
    else if (!strobe.refRun) refCnt <= '0;
    else if (refTick)        refCnt <= '0;
    else                     refCnt <= refCnt + 1'b1;
  end

endmodule

// File: rtl/memInitCtrl.sv
module memInitCtrl
  import memInitPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enSync,
  input  logic        puDone,
  input  logic        refTick,
  input  logic        reqAck,
  output ctrlStrobe_t strobe,
  output logic        reqValid,
  output logic [1:0]  reqKind,
  output logic        initDone
);

  upkeepState_e state, stateNxt;
  logic         refPend, refPendNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_WAITEN: if (enSync) stateNxt = ST_PWRUP;
      ST_PWRUP:  if (puDone) stateNxt = ST_PRE;
      ST_PRE:    if (reqAck) stateNxt = ST_REF1;
      ST_REF1:   if (reqAck) stateNxt = ST_REF2;
      ST_REF2:   if (reqAck) stateNxt = ST_MRS;
      ST_MRS:    if (reqAck) stateNxt = ST_RUN;
      default:   stateNxt = ST_RUN;
    endcase
  end

  // A new expiry wins over an acknowledge in the same cycle
  always_comb begin
    if (state != ST_RUN) refPendNxt = 1'b0;
    else                 refPendNxt = refTick | (refPend & ~reqAck);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WAITEN;
      refPend <= 1'b0;
    end else begin
      state   <= stateNxt;
      refPend <= refPendNxt;
    end
  end

  always_comb begin
    reqValid = 1'b0;
    reqKind  = KIND_REFRESH;
    case (state)
      ST_PRE:  begin reqValid = 1'b1; reqKind = KIND_PRECHARGE; end
      ST_REF1: begin reqValid = 1'b1; reqKind = KIND_REFRESH;   end
      ST_REF2: begin reqValid = 1'b1; reqKind = KIND_REFRESH;   end
      ST_MRS:  begin reqValid = 1'b1; reqKind = KIND_MODELOAD;  end
      ST_RUN:  begin reqValid = refPend; reqKind = KIND_REFRESH; end
      default: ;
    endcase
  end

  assign initDone      = (state == ST_RUN);
  assign strobe.puRun  = (state == ST_PWRUP);
  assign strobe.refRun = (state == ST_RUN);

endmodule

// File: rtl/dramUpkeepSched.sv
module dramUpkeepSched
  import memInitPkg::*;
#(
  parameter int POWERUP_CYCLES   = 10000,
  parameter int REFRESH_PERIOD   = 1560,
  parameter int REFRESH_W        = 12,
  parameter int CAS_LATENCY      = 3,
  parameter int BURST_LEN        = 8,
  parameter bit BURST_INTERLEAVE = 1'b0,
  parameter bit WRITE_SINGLE     = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enableAsync,
  input  logic              reqAck,
  output logic              reqValid,
  output logic [1:0]        reqKind,
  output logic [MODE_W-1:0] modeWord,
  output logic              initDone
);

  localparam logic [MODE_W-1:0] MODE_VALUE =
    buildModeWord(CAS_LATENCY, BURST_LEN, BURST_INTERLEAVE, WRITE_SINGLE);

  ctrlStrobe_t strobe;
  logic        enSync, puDone, refTick;

  memInitDatapath #(
    .SYNC_STAGES(2),
    .PU_CYCLES  (POWERUP_CYCLES),
    .REF_PERIOD (REFRESH_PERIOD),
    .REF_W      (REFRESH_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .enableAsync(enableAsync),
    .strobe     (strobe),
    .enSync     (enSync),
    .puDone     (puDone),
    .refTick    (refTick)
  );

  memInitCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enSync  (enSync),
    .puDone  (puDone),
    .refTick (refTick),
    .reqAck  (reqAck),
    .strobe  (strobe),
    .reqValid(reqValid),
    .reqKind (reqKind),
    .initDone(initDone)
  );

  assign modeWord = MODE_VALUE;

endmodule

// File: rtl/dramUpkeepSched_chk.sv
module dramUpkeepSched_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqAck,
  input logic       reqValid,
  input logic [1:0] reqKind,
  input logic       initDone
);

  // R4: request and kind held until accepted
  p_hold_until_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqAck) |=> (reqValid && $stable(reqKind)));

  // R3: precharge-all is followed by auto-refresh
  p_init_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAck && reqKind == 2'd0) |=> (reqValid && reqKind == 2'd1));

  // R5: accepted mode load completes initialization
  p_mrs_completes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAck && reqKind == 2'd2) |=> initDone);

  // R5: completion is sticky
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R7: after initialization only refresh requests appear
  p_run_refresh_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && reqValid) |-> (reqKind == 2'd1));

endmodule

bind dramUpkeepSched dramUpkeepSched_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqAck  (reqAck),
  .reqValid(reqValid),
  .reqKind (reqKind),
  .initDone(initDone)
);

// File: tb/dramUpkeepSched_bench.sv
module dramUpkeepSched_bench;

  localparam int PU  = 40;
  localparam int PER = 60;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enableAsync = 1'b0;
  logic        reqAck = 1'b0;
  logic        reqValid;
  logic [1:0]  reqKind;
  logic [11:0] modeWord;
  logic        initDone;

  dramUpkeepSched #(
    .POWERUP_CYCLES  (PU),
    .REFRESH_PERIOD  (PER),
    .REFRESH_W       (12),
    .CAS_LATENCY     (2),
    .BURST_LEN       (4),
    .BURST_INTERLEAVE(1'b1),
    .WRITE_SINGLE    (1'b1)
  ) u_dramUpkeepSched (
    .clk        (clk),
    .rstN       (rstN),
    .enableAsync(enableAsync),
    .reqAck     (reqAck),
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .modeWord   (modeWord),
    .initDone   (initDone)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  logic [1:0] expQ[$];
  logic [1:0] expKind;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // Driver: queue the expected kind, then accept for one cycle
  task automatic ackNow(logic [1:0] k);
    expQ.push_back(k);
    reqAck = 1'b1;
    tick();
    reqAck = 1'b0;
  endtask

  task automatic waitReq();
    for (int g = 0; g < 5000 && !reqValid; g++) tick();
  endtask

  // Monitor: compare each accepted request against the scoreboard
  always @(negedge clk) begin
    #3;
    if (reqAck && reqValid) begin
      if (expQ.size() == 0) chk("R3 unexpected accept", 1, 0);
      else begin
        expKind = expQ.pop_front();
        chk("R3 accepted kind", int'(reqKind), int'(expKind));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, runStart, r, bad;

    repeat (5) tick();
    chk("R1 reset reqValid", int'(reqValid), 0);
    chk("R1 reset initDone", int'(initDone), 0);

    rstN = 1'b1;
    bad = 0;
    for (int i = 0; i < 80; i++) begin
      tick();
      if (reqValid || initDone) bad = 1;
    end
    chk("R1 idle while enable low", bad, 0);

    // R10: stray accept while disabled
    reqAck = 1'b1;
    tick();
    reqAck = 1'b0;
    tick();
    chk("R10 stray accept when disabled", int'(reqValid), 0);

    enableAsync = 1'b1;
    n = cyc;
    waitReq();
    chk("R2 first request delay", cyc - n, PU + 3);
    chk("R3 first kind precharge", int'(reqKind), 0);

    repeat (3) tick();
    chk("R4 held without accept", int'(reqValid), 1);
    chk("R4 kind stable", int'(reqKind), 0);

    ackNow(2'd0);
    chk("R4 advance to refresh", int'(reqKind), 1);
    tick();
    ackNow(2'd1);
    ackNow(2'd1);
    chk("R3 mode load kind", int'(reqKind), 2);
    chk("R6 mode word", int'(modeWord), 'h22A);
    chk("R5 not done before load", int'(initDone), 0);

    ackNow(2'd2);
    chk("R5 initDone after load", int'(initDone), 1);
    chk("R5 channel idle", int'(reqValid), 0);
    runStart = cyc;

    waitReq();
    chk("R7 first refresh", cyc - runStart, PER);
    chk("R7 refresh kind", int'(reqKind), 1);
    tick();
    ackNow(2'd1);
    chk("R4 idle after accept", int'(reqValid), 0);
    waitReq();
    chk("R7 second period", cyc - runStart, 2 * PER);

    // R8: leave pending across two expiries
    r = cyc;
    bad = 0;
    for (int i = 0; i < 150; i++) begin
      tick();
      if (!reqValid) bad = 1;
    end
    chk("R8 stays pending", bad, 0);
    ackNow(2'd1);
    chk("R8 one accept clears", int'(reqValid), 0);
    waitReq();
    chk("R8 phase kept", cyc - r, 3 * PER);

    // R9: accept in the cycle of the next expiry
    r = cyc;
    repeat (PER - 1) tick();
    ackNow(2'd1);
    chk("R9 back-to-back request", int'(reqValid), 1);
    tick();
    chk("R9 still pending", int'(reqValid), 1);
    ackNow(2'd1);
    chk("R9 cleared by second accept", int'(reqValid), 0);

    // R10: accept with nothing pending
    reqAck = 1'b1;
    tick();
    reqAck = 1'b0;
    chk("R10 no request from stray accept", int'(reqValid), 0);
    waitReq();
    chk("R10 phase unchanged", cyc - r, 2 * PER);
    ackNow(2'd1);
    repeat (3) tick();

    chk("R3 scoreboard drained", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule